// File: doc/BRIEF.md
# CAN Identifier Mask/Code Acceptance Filter

This block decides, frame by frame, whether a received CAN identifier is wanted by the local node. Software loads two 8-bit registers through a simple write port. One is a code register that holds the required identifier pattern. The other is a mask register in which every set bit frees the matching identifier bit from comparison. Only the eight most significant bits of the 11-bit identifier take part in the test. The three low bits never influence the outcome.

When the receive path finishes an identifier, it raises a one-cycle valid strobe. One clock later the block presents a registered pass/fail flag together with a one-cycle done pulse. The flag keeps its value until the next frame is judged. Two counters record how many frames passed and how many failed, and each counter stops at its maximum value. After reset the mask frees every bit, so every frame passes until software narrows the filter.

Top module: `can_id_filter`

## Requirements
- R1: After reset the code register is 0x00 and the mask register is 0xFF. `accept` and `done` are low and both counters read zero.
- R2: `done` is high for exactly the one cycle that follows a cycle with `id_valid` high, and it is low at all other times.
- R3: A mask bit of 1 makes the matching identifier bit a don't-care. Identifier bit `id[3+k]` pairs with mask bit k.
- R4: Every identifier bit `id[3+k]` whose mask bit k is 0 must equal code bit k for the frame to pass. A single mismatch makes `accept` low.
- R5: Identifier bits `id[2:0]` have no effect on the decision.
- R6: A register write in the same cycle as `id_valid` does not affect that frame's decision. It applies from the next frame onward.
- R7: `accept` keeps its value in every cycle that does not follow an `id_valid` cycle.
- R8: Each judged frame adds exactly one to `acc_cnt` if it passed, or to `rej_cnt` if it failed. The count becomes visible in the same cycle as `done`, and a counter at all ones stays there.
- R9: A write with `wr_sel` = 0 loads the code register and a write with `wr_sel` = 1 loads the mask register. The other register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 code, 1 mask |
| wr_data | input | FLT_W (8) | Write data |
| id_valid | input | 1 | Identifier complete strobe |
| id | input | ID_W (11) | Received identifier |
| accept | output | 1 | Registered pass flag of last frame |
| done | output | 1 | One-cycle pulse: decision ready |
| acc_cnt | output | CNT_W (16) | Saturating count of passed frames |
| rej_cnt | output | CNT_W (16) | Saturating count of failed frames |

## Verification
A register write and a frame judgement can land in the same cycle. The bench provokes this by raising `wr_en` and `id_valid` on one edge, with the written value chosen so that it flips the outcome for that identifier. The bench then expects the decision made with the old register contents. A second frame with the same identifier must show the new outcome. Counter saturation is reached by instantiating narrow counters and sending more frames than they can hold.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
    typedef enum logic {
        SEL_CODE = 1'b0,
        SEL_MASK = 1'b1
    } flt_sel_e;
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
    import can_flt_pkg::*;
#(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [FLT_W-1:0] wr_data,
    output logic [FLT_W-1:0] code,
    output logic [FLT_W-1:0] mask
);
    typedef struct packed {
        logic [FLT_W-1:0] code;
        logic [FLT_W-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (flt_sel_e'(wr_sel) == SEL_MASK) st_d.mask = wr_data;
            else                                st_d.code = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign mask = st_q.mask;
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match #(
    parameter int FLT_W = 8
) (
    input  logic [FLT_W-1:0] id_hi,
    input  logic [FLT_W-1:0] code,
    input  logic [FLT_W-1:0] mask,
    output logic             pass
);
    logic [FLT_W-1:0] bit_ok;

    for (genvar k = 0; k < FLT_W; k++) begin : g_bit
        assign bit_ok[k] = (id_hi[k] ~^ code[k]) | mask[k];
    end

    assign pass = &bit_ok;
endmodule

// File: rtl/can_flt_tally.sv
module can_flt_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  logic             pass,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] rej_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] rej;
    } tally_t;

    tally_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_vld) begin
            if (pass) begin
                if (st_q.acc != CNT_MAX) st_d.acc = st_q.acc + 1'b1;
            end else begin
                if (st_q.rej != CNT_MAX) st_d.rej = st_q.rej + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_cnt = st_q.acc;
    assign rej_cnt = st_q.rej;
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter #(
    parameter int ID_W  = 11,
    parameter int FLT_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [FLT_W-1:0] wr_data,
    input  logic             id_valid,
    input  logic [ID_W-1:0]  id,
    output logic             accept,
    output logic             done,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] rej_cnt
);
    localparam int FLT_LSB = ID_W - FLT_W;

    typedef struct packed {
        logic accept;
        logic done;
    } dec_t;

    logic [FLT_W-1:0] code, mask;
    logic             pass;
    dec_t             dec_d, dec_q;

    can_flt_regs #(.FLT_W(FLT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .code    (code),
        .mask    (mask)
    );

    can_flt_match #(.FLT_W(FLT_W)) u_match (
        .id_hi (id[ID_W-1:FLT_LSB]),
        .code  (code),
        .mask  (mask),
        .pass  (pass)
    );

    can_flt_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (id_valid),
        .pass      (pass),
        .acc_cnt   (acc_cnt),
        .rej_cnt   (rej_cnt)
    );

    if (FLT_LSB > 0) begin : g_low
        logic unused_low;
        assign unused_low = ^id[FLT_LSB-1:0];
    end

    always_comb begin
        dec_d      = dec_q;
        dec_d.done = id_valid;
        if (id_valid) dec_d.accept = pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign accept = dec_q.accept;
    assign done   = dec_q.done;
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic             accept,
    input logic             done,
    input logic [CNT_W-1:0] acc_cnt,
    input logic [CNT_W-1:0] rej_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    p_done_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> done);

    p_done_only_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> !done);

    p_accept_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> $stable(accept));

    p_acc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> ((acc_cnt == $past(acc_cnt) + 1'b1) ||
                              (acc_cnt == CMAX && $past(acc_cnt) == CMAX)));

    p_rej_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |-> ((rej_cnt == $past(rej_cnt) + 1'b1) ||
                               (rej_cnt == CMAX && $past(rej_cnt) == CMAX)));

    p_acc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && accept) |-> $stable(acc_cnt));

    p_rej_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && !accept) |-> $stable(rej_cnt));
endmodule

bind can_id_filter can_id_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_valid (id_valid),
    .accept   (accept),
    .done     (done),
    .acc_cnt  (acc_cnt),
    .rej_cnt  (rej_cnt)
);

// File: tb/can_id_filter_bench.sv
module can_id_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W  = 11;
    localparam int FLT_W = 8;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [FLT_W-1:0] wr_data = '0;
    logic             id_valid = 1'b0;
    logic [ID_W-1:0]  id = '0;
    logic             accept, done;
    logic [CNT_W-1:0] acc_cnt, rej_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_acc = 0;
    int exp_rej = 0;
    logic [FLT_W-1:0] m_code = 8'h00;
    logic [FLT_W-1:0] m_mask = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_id_filter #(.ID_W(ID_W), .FLT_W(FLT_W), .CNT_W(CNT_W)) u_can_id_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .id_valid(id_valid), .id(id), .accept(accept), .done(done),
        .acc_cnt(acc_cnt), .rej_cnt(rej_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit model_pass(input logic [ID_W-1:0] fid);
        return ((fid[ID_W-1:ID_W-FLT_W] ^ m_code) & ~m_mask) == '0;
    endfunction

    task automatic note_count(input bit p);
        if (p) begin if (exp_acc < CMAX) exp_acc++; end
        else   begin if (exp_rej < CMAX) exp_rej++; end
    endtask

    task automatic write_reg(input logic sel, input logic [FLT_W-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_mask = val; else m_code = val;
    endtask

    // send a frame and check the decision one cycle after the strobe
    task automatic frame(input logic [ID_W-1:0] fid, input string req);
        bit p;
        p = model_pass(fid);
        @(negedge clk);
        id = fid; id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
        note_count(p);
        check({req, " accept"}, accept, p);
        check("R2 done pulse", done, 1);
        check("R8 acc_cnt", acc_cnt, exp_acc);
        check("R8 rej_cnt", rej_cnt, exp_rej);
        @(negedge clk);
        check("R2 done low", done, 0);
        check("R7 accept held", accept, p);
    endtask

    task automatic t_reset;
        check("R1 accept", accept, 0);
        check("R1 done", done, 0);
        check("R1 acc_cnt", acc_cnt, 0);
        check("R1 rej_cnt", rej_cnt, 0);
        frame(11'h7FF, "R1 mask all");
        frame(11'h2A5, "R1 mask all");
    endtask

    task automatic t_exact;
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'hA5);
        frame({8'hA5, 3'b000}, "R4 match");
        frame({8'hA4, 3'b000}, "R4 lsb miss");
        frame({8'h25, 3'b000}, "R4 msb miss");
        frame({8'h5A, 3'b000}, "R4 all miss");
    endtask

    task automatic t_mask;
        write_reg(1'b1, 8'h0F);
        frame({8'hA0, 3'b000}, "R3 low nibble free");
        frame({8'hAF, 3'b000}, "R3 low nibble free");
        frame({8'hB0, 3'b000}, "R3 high nibble kept");
        write_reg(1'b1, 8'h80);
        frame({8'h25, 3'b000}, "R3 msb free");
    endtask

    task automatic t_low_bits;
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'h3C);
        for (int b = 0; b < 8; b++) frame({8'h3C, 3'(b)}, "R5 low bits pass");
        for (int b = 0; b < 8; b++) frame({8'h3D, 3'(b)}, "R5 low bits fail");
    endtask

    task automatic t_select;
        write_reg(1'b0, 8'h11);
        frame({8'h11, 3'b000}, "R9 code loaded");
        frame({8'h3C, 3'b000}, "R9 old code gone");
        write_reg(1'b1, 8'hFF);
        frame({8'h3C, 3'b000}, "R9 mask loaded");
        write_reg(1'b1, 8'h00);
        frame({8'h11, 3'b000}, "R9 code kept");
    endtask

    // write and frame on the same edge
    task automatic t_collide;
        bit p_old;
        p_old = model_pass({8'h11, 3'b000});
        @(negedge clk);
        id = {8'h11, 3'b000}; id_valid = 1'b1;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h22;
        @(negedge clk);
        id_valid = 1'b0; wr_en = 1'b0;
        m_code = 8'h22;
        note_count(p_old);
        check("R6 old value used", accept, 1);
        check("R6 done", done, 1);
        frame({8'h11, 3'b000}, "R6 new value next");
        frame({8'h22, 3'b000}, "R6 new value next");
    endtask

    task automatic t_saturate;
        write_reg(1'b1, 8'hFF);
        for (int n = 0; n < CMAX + 3; n++) frame(11'h001, "R8 saturate pass");
        check("R8 acc sat", acc_cnt, CMAX);
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'h00);
        for (int n = 0; n < CMAX + 3; n++) frame(11'h7F8, "R8 saturate fail");
        check("R8 rej sat", rej_cnt, CMAX);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_mask();
        t_low_bits();
        t_select();
        t_collide();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule